// File: doc/BRIEF.md
# Mailbox Command Exchange Sequencer

This block runs a whole command exchange with an attached microcontroller over a byte-wide mailbox, so that software or a higher-level controller never has to step through the bytes itself. The caller presents an opcode, up to `MAX_IN` argument bytes with a count, and the number of reply bytes it expects, then pulses `start`. The sequencer first empties any leftover bytes from the receive side. It then writes the opcode and the argument bytes, reads back one acknowledge byte, and finally reads the reply bytes.

Every byte moved is gated on the mailbox flags: a write waits for room on the transmit side, and a read waits for data on the receive side. Each wait is bounded by `TIMEOUT` cycles. On completion or abort a one-cycle `done` pulse is given. The acknowledge byte, the reply bytes and a 16-bit word packed from the first two reply bytes then stay readable until the next accepted start. Typical use is a status query with no arguments and a two-byte reply, for example opcode 0x0C or 0x11, whose result is taken from `out_word`.

Top module: `cmd_xchg_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `tx_wr`, `rx_rd` and `timed_out` are 0, and `ack_byte`, `out_bytes` and `out_word` are zero. A `start` seen while idle is accepted and `busy` is 1 in the next cycle. A `start` seen while `busy` is 1 is ignored.
- R2: Before the opcode is written, every byte already waiting in the receive mailbox is popped, one per cycle, and discarded. None of these bytes becomes the acknowledge byte or a reply byte.
- R3: The first byte written is the opcode. Next come exactly min(`in_count`, `MAX_IN`) argument bytes in rising index order, where argument i is `in_bytes[8*i+7:8*i]`. All inputs are captured at the accepted start, so later changes have no effect on the exchange.
- R4: `tx_wr` is asserted only in a cycle where `tx_not_full` is 1, and `rx_rd` only in a cycle where `rx_not_empty` is 1. Data moves on the rising edge where the strobe is high.
- R5: Exactly one byte is read after the last argument byte and before any reply byte. It appears on `ack_byte` and is not stored in `out_bytes`.
- R6: Then min(`out_count`, `MAX_OUT`) reply bytes are read. Reply j is stored at `out_bytes[8*j+7:8*j]`. Positions that are not filled read as zero.
- R7: `out_word` is the first reply byte in bits 15:8 and the second reply byte in bits 7:0.
- R8: If a wait sees its flag false for `TIMEOUT` consecutive cycles, the exchange aborts. `timed_out` is then 1 with the `done` pulse, and the block returns to idle. With no stale bytes, the exchange holds `busy` for `TIMEOUT`+2 cycles when the opcode write stalls, and for `TIMEOUT`+3 cycles when the acknowledge never arrives after a zero-argument command.
- R9: `done` is high for exactly one cycle per accepted start. `ack_byte`, `out_bytes`, `out_word` and `timed_out` are held from then until the next accepted start. A successful exchange leaves `timed_out` at 0.
- R10: With no stall and no stale bytes, `busy` stays high for 4 + arguments + replies cycles. Each stale byte adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an exchange (taken only when idle) |
| opcode | input | 8 | Command byte |
| in_count | input | IN_CW | Number of argument bytes requested |
| in_bytes | input | 8*MAX_IN | Argument bytes, index i in bits 8i+7:8i |
| out_count | input | OUT_CW | Number of reply bytes requested |
| tx_not_full | input | 1 | Transmit mailbox can take a byte |
| tx_wr | output | 1 | Write strobe to the transmit mailbox |
| tx_data | output | 8 | Byte being written |
| rx_not_empty | input | 1 | Receive mailbox holds a byte |
| rx_data | input | 8 | Byte at the head of the receive mailbox |
| rx_rd | output | 1 | Pop strobe for the receive mailbox |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Last exchange aborted on a wait limit |
| ack_byte | output | 8 | Acknowledge byte of the last exchange |
| out_bytes | output | 8*MAX_OUT | Reply bytes, index j in bits 8j+7:8j |
| out_word | output | 16 | First reply byte high, second low |

## Verification
The bench builds the block with `MAX_IN` = 4, `MAX_OUT` = 4 and `TIMEOUT` = 20. These values make the clamping of over-long counts reachable through a 3-bit count field. They also keep every abort path within a few dozen cycles, so the exact busy length of a stalled opcode write, a missing acknowledge and a truncated reply can each be checked.

// File: rtl/cmdseq_pkg.sv
`timescale 1ns/1ps
package cmdseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_SEND_OP,
    ST_SEND_IN,
    ST_WAIT_ACK,
    ST_RECV_OUT,
    ST_DONE
  } seq_state_e;

  // Larger of two sizes, used to size the shared byte index.
  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // A requested count never exceeds the buffer it refers to.
  function automatic int unsigned clamp_count(int unsigned req, int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  // Two-byte reply: first byte received is the high half.
  function automatic logic [15:0] pack_hi_lo(logic [7:0] first, logic [7:0] second);
    return {first, second};
  endfunction

endpackage

// File: rtl/seq_wait_timer.sv
`timescale 1ns/1ps
module seq_wait_timer #(
  parameter int TIMEOUT = 10000,
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q;

  // Counts consecutive cycles in a waiting state whose flag is false.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || hit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign expired = run && !hit && (cnt_q == CNT_W'(TIMEOUT - 1));

endmodule

// File: rtl/seq_reply_store.sv
`timescale 1ns/1ps
module seq_reply_store #(
  parameter int MAX_OUT = 8,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 ack_we,
  input  logic                 out_we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           din,
  output logic [7:0]           ack_byte,
  output logic [8*MAX_OUT-1:0] out_flat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_byte <= 8'h00;
    end else if (clr) begin
      ack_byte <= 8'h00;
    end else if (ack_we) begin
      ack_byte <= din;
    end
  end

  for (genvar k = 0; k < MAX_OUT; k++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(k);
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= 8'h00;
      end else if (clr) begin
        slot_q <= 8'h00;
      end else if (out_we && (idx == SLOT)) begin
        slot_q <= din;
      end
    end
    assign out_flat[8*k +: 8] = slot_q;
  end

endmodule

// File: rtl/cmd_xchg_seq.sv
`timescale 1ns/1ps
module cmd_xchg_seq #(
  parameter int MAX_IN  = 8,
  parameter int MAX_OUT = 8,
  parameter int TIMEOUT = 10000,
  localparam int IN_CW  = $clog2(MAX_IN + 1),
  localparam int OUT_CW = $clog2(MAX_OUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [7:0]           opcode,
  input  logic [IN_CW-1:0]     in_count,
  input  logic [8*MAX_IN-1:0]  in_bytes,
  input  logic [OUT_CW-1:0]    out_count,
  input  logic                 tx_not_full,
  output logic                 tx_wr,
  output logic [7:0]           tx_data,
  input  logic                 rx_not_empty,
  input  logic [7:0]           rx_data,
  output logic                 rx_rd,
  output logic                 busy,
  output logic                 done,
  output logic                 timed_out,
  output logic [7:0]           ack_byte,
  output logic [8*MAX_OUT-1:0] out_bytes,
  output logic [15:0]          out_word
);
  import cmdseq_pkg::*;

  localparam int IDX_W = $clog2(max_of(MAX_IN, MAX_OUT) + 1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] nin_q, nout_q;
  logic [7:0]       op_q;
  logic [7:0]       in_q [MAX_IN];
  logic             timed_out_q;

  // Named internal events, also observed by the checker.
  logic start_take;
  logic wait_run;
  logic wait_hit;
  logic wait_expired;
  logic ack_we;
  logic out_we;
  logic last_in;
  logic last_out;
  logic [7:0] in_sel;

  assign start_take = start && (st_q == ST_IDLE);
  assign last_in    = (idx_q == nin_q - IDX_W'(1));
  assign last_out   = (idx_q == nout_q - IDX_W'(1));

  always_comb begin
    in_sel = 8'h00;
    for (int k = 0; k < MAX_IN; k++) begin
      if (idx_q == k[IDX_W-1:0]) in_sel = in_q[k];
    end
  end

  // Mailbox strobes: each one qualified by its own flag.
  assign tx_wr   = ((st_q == ST_SEND_OP) || (st_q == ST_SEND_IN)) && tx_not_full;
  assign tx_data = (st_q == ST_SEND_OP) ? op_q : in_sel;
  assign rx_rd   = ((st_q == ST_DRAIN) || (st_q == ST_WAIT_ACK) || (st_q == ST_RECV_OUT))
                   && rx_not_empty;
  assign ack_we  = rx_rd && (st_q == ST_WAIT_ACK);
  assign out_we  = rx_rd && (st_q == ST_RECV_OUT);

  always_comb begin
    wait_run = 1'b0;
    wait_hit = 1'b0;
    unique case (st_q)
      ST_DRAIN:                 begin wait_run = 1'b1; wait_hit = !rx_not_empty; end
      ST_SEND_OP, ST_SEND_IN:   begin wait_run = 1'b1; wait_hit = tx_not_full;   end
      ST_WAIT_ACK, ST_RECV_OUT: begin wait_run = 1'b1; wait_hit = rx_not_empty;  end
      default:                  begin wait_run = 1'b0; wait_hit = 1'b0;          end
    endcase
  end

  seq_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_run),
    .hit     (wait_hit),
    .expired (wait_expired)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_take) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (wait_expired)       st_d = ST_DONE;
        else if (!rx_not_empty) st_d = ST_SEND_OP;
      end
      ST_SEND_OP: begin
        if (wait_expired) begin
          st_d = ST_DONE;
        end else if (tx_not_full) begin
          idx_d = '0;
          st_d  = (nin_q == '0) ? ST_WAIT_ACK : ST_SEND_IN;
        end
      end
      ST_SEND_IN: begin
        if (wait_expired) begin
          st_d = ST_DONE;
        end else if (tx_not_full) begin
          if (last_in) begin
            idx_d = '0;
            st_d  = ST_WAIT_ACK;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_WAIT_ACK: begin
        if (wait_expired) begin
          st_d = ST_DONE;
        end else if (rx_not_empty) begin
          idx_d = '0;
          st_d  = (nout_q == '0) ? ST_DONE : ST_RECV_OUT;
        end
      end
      ST_RECV_OUT: begin
        if (wait_expired) begin
          st_d = ST_DONE;
        end else if (rx_not_empty) begin
          if (last_out) st_d = ST_DONE;
          else          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      nin_q       <= '0;
      nout_q      <= '0;
      op_q        <= 8'h00;
      timed_out_q <= 1'b0;
      for (int k = 0; k < MAX_IN; k++) in_q[k] <= 8'h00;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (start_take) begin
        op_q        <= opcode;
        nin_q       <= IDX_W'(clamp_count(32'(in_count), MAX_IN));
        nout_q      <= IDX_W'(clamp_count(32'(out_count), MAX_OUT));
        timed_out_q <= 1'b0;
        for (int k = 0; k < MAX_IN; k++) in_q[k] <= in_bytes[8*k +: 8];
      end else if (wait_expired) begin
        timed_out_q <= 1'b1;
      end
    end
  end

  seq_reply_store #(.MAX_OUT(MAX_OUT), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_take),
    .ack_we   (ack_we),
    .out_we   (out_we),
    .idx      (idx_q),
    .din      (rx_data),
    .ack_byte (ack_byte),
    .out_flat (out_bytes)
  );

  assign out_word  = pack_hi_lo(out_bytes[7:0], out_bytes[15:8]);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign timed_out = timed_out_q;

endmodule

// File: rtl/cmd_xchg_seq_chk.sv
`timescale 1ns/1ps
module cmd_xchg_seq_chk #(
  parameter int MAX_OUT = 8,
  parameter int TIMEOUT = 10000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 tx_wr,
  input logic                 tx_not_full,
  input logic                 rx_rd,
  input logic                 rx_not_empty,
  input logic                 timed_out,
  input logic                 wait_expired,
  input logic [7:0]           ack_byte,
  input logic [15:0]          out_word,
  input logic [8*MAX_OUT-1:0] out_bytes
);

  // Consecutive in-flight cycles that moved no byte.
  int unsigned stall_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             stall_q <= 0;
    else if (busy && !done && !tx_wr && !rx_rd) stall_q <= stall_q + 1;
    else                                    stall_q <= 0;
  end

  assert_start_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_tx_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> tx_not_full);

  assert_rx_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |-> rx_not_empty);

  assert_one_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_wr && rx_rd));

  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q <= TIMEOUT + 1);

  assert_abort_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired |=> (done && timed_out));

  assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ack_byte) && $stable(out_word)
                           && $stable(out_bytes) && $stable(timed_out)));

endmodule

bind cmd_xchg_seq cmd_xchg_seq_chk #(.MAX_OUT(MAX_OUT), .TIMEOUT(TIMEOUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .tx_wr        (tx_wr),
  .tx_not_full  (tx_not_full),
  .rx_rd        (rx_rd),
  .rx_not_empty (rx_not_empty),
  .timed_out    (timed_out),
  .wait_expired (wait_expired),
  .ack_byte     (ack_byte),
  .out_word     (out_word),
  .out_bytes    (out_bytes)
);

// File: tb/cmd_xchg_seq_test.sv
`timescale 1ns/1ps
module cmd_xchg_seq_test;

  localparam int MI = 4;
  localparam int MO = 4;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [2:0] in_count = 3'd0;
  logic [8*MI-1:0] in_bytes = '0;
  logic [2:0] out_count = 3'd0;
  logic tx_not_full = 1'b0;
  logic tx_wr;
  logic [7:0] tx_data;
  logic rx_not_empty = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_rd;
  logic busy, done, timed_out;
  logic [7:0] ack_byte;
  logic [8*MO-1:0] out_bytes;
  logic [15:0] out_word;

  always #2.5 clk = ~clk;

  cmd_xchg_seq #(.MAX_IN(MI), .MAX_OUT(MO), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .in_count(in_count), .in_bytes(in_bytes), .out_count(out_count),
    .tx_not_full(tx_not_full), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_not_empty(rx_not_empty), .rx_data(rx_data), .rx_rd(rx_rd),
    .busy(busy), .done(done), .timed_out(timed_out),
    .ack_byte(ack_byte), .out_bytes(out_bytes), .out_word(out_word)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Microcontroller model: queues of bytes, behavioural timing.
  logic [7:0] sent_q[$];
  logic [7:0] rx_q[$];
  int   popped = 0;
  int   expect_tx = 1;
  bit   replied = 0;
  bit   dev_mute = 0;
  bit   dev_block = 0;
  bit   dev_thr = 0;
  logic [7:0]  dev_ack = 8'h00;
  logic [31:0] dev_rep = '0;
  int   dev_nrep = 0;
  int   busy_cyc = 0;
  int   done_cnt = 0;
  logic [7:0]  done_ack = 8'h00;
  logic [15:0] done_word = 16'h0;
  bit   pend_tx = 0, pend_rx = 0;
  logic [7:0] pend_txd = 8'h00;
  int   cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_tx) sent_q.push_back(pend_txd);
      if (pend_rx) begin
        popped++;
        void'(rx_q.pop_front());
      end
      if (pend_tx && !dev_mute && !replied && sent_q.size() == expect_tx) begin
        rx_q.push_back(dev_ack);
        for (int i = 0; i < dev_nrep; i++) rx_q.push_back(dev_rep[8*i +: 8]);
        replied = 1;
      end
    end
    cyc++;
    tx_not_full  = dev_block ? 1'b0 : (dev_thr ? cyc[0] : 1'b1);
    rx_not_empty = (rx_q.size() > 0);
    rx_data      = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
    #1;
    pend_tx  = tx_wr;
    pend_txd = tx_data;
    pend_rx  = rx_rd;
    // R4: compared every clock against the model's own flags
    if (tx_wr) check(tx_not_full, "R4 write without room", 64'(tx_wr), 64'(tx_not_full));
    if (rx_rd) check(rx_not_empty, "R4 pop while empty", 64'(rx_rd), 64'(rx_not_empty));
    if (busy) busy_cyc++;
    if (done) begin
      done_cnt++;
      done_ack  = ack_byte;
      done_word = out_word;
    end
  end

  task automatic run_txn(input logic [7:0] op, input int nin, input logic [31:0] inb,
                         input int nout, input logic [7:0] ack, input logic [31:0] rep,
                         input int nrep, input bit mute, input bit block, input bit thr,
                         input int stale, input bit poke, input int exp_busy,
                         input bit exp_to);
    int ein, eout, stored;
    logic [8*MO-1:0] exp_out;
    logic [7:0] exp_ack;
    @(posedge clk); #1;
    sent_q.delete();
    rx_q.delete();
    for (int k = 0; k < stale; k++) rx_q.push_back(8'hE0 + 8'(k));
    ein = (nin > MI) ? MI : nin;
    eout = (nout > MO) ? MO : nout;
    popped = 0; replied = 0; dev_mute = mute; dev_block = block; dev_thr = thr;
    dev_ack = ack; dev_rep = rep; dev_nrep = nrep; expect_tx = 1 + ein;
    busy_cyc = 0; done_cnt = 0;
    start = 1'b1; opcode = op; in_count = 3'(nin); in_bytes = inb; out_count = 3'(nout);
    @(posedge clk); #1;
    start = 1'b0; opcode = 8'h99; in_bytes = '1; in_count = 3'd7; out_count = 3'd0;
    if (poke) begin
      @(posedge clk); #1;
      start = 1'b1; opcode = 8'h77;
      @(posedge clk); #1;
      start = 1'b0;
    end
    for (int w = 0; w < 300 && done_cnt == 0; w++) begin
      @(posedge clk); #1;
    end
    repeat (4) @(posedge clk);
    #1;
    dev_block = 0; dev_thr = 0;
    stored = (mute || block) ? 0 : ((nrep < eout) ? nrep : eout);
    exp_out = '0;
    for (int i = 0; i < stored; i++) exp_out[8*i +: 8] = rep[8*i +: 8];
    exp_ack = (mute || block) ? 8'h00 : ack;
    check(done_cnt == 1, "R9 done pulse count", 64'(done_cnt), 64'd1);
    if (block) begin
      check(sent_q.size() == 0, "R8 nothing sent when blocked", 64'(sent_q.size()), 64'd0);
    end else begin
      check(sent_q.size() == 1 + ein, "R3 bytes sent", 64'(sent_q.size()), 64'(1 + ein));
      if (sent_q.size() == 1 + ein) begin
        check(sent_q[0] == op, "R3 opcode first", 64'(sent_q[0]), 64'(op));
        for (int i = 0; i < ein; i++)
          check(sent_q[1+i] == inb[8*i +: 8], "R3 argument order",
                64'(sent_q[1+i]), 64'(inb[8*i +: 8]));
      end
    end
    check(ack_byte == exp_ack, "R5 ack byte", 64'(ack_byte), 64'(exp_ack));
    check(out_bytes == exp_out, "R6 reply bytes", 64'(out_bytes), 64'(exp_out));
    check(out_word == {exp_out[7:0], exp_out[15:8]}, "R7 packed word",
          64'(out_word), 64'({exp_out[7:0], exp_out[15:8]}));
    check(timed_out == exp_to, "R8 timeout flag", 64'(timed_out), 64'(exp_to));
    check(popped == stale + ((mute || block) ? 0 : 1 + stored), "R2 bytes popped",
          64'(popped), 64'(stale + ((mute || block) ? 0 : 1 + stored)));
    if (exp_busy >= 0)
      check(busy_cyc == exp_busy, "R10 busy length", 64'(busy_cyc), 64'(exp_busy));
    check(ack_byte == done_ack && out_word == done_word, "R9 result held",
          64'({ack_byte, out_word}), 64'({done_ack, done_word}));
    check(!busy, "R1 idle after exchange", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!busy && !done && !tx_wr && !rx_rd && !timed_out, "R1 reset strobes",
          64'({busy, done, tx_wr, rx_rd, timed_out}), 64'd0);
    check(ack_byte == 0 && out_bytes == 0 && out_word == 0, "R1 reset results",
          64'({ack_byte, out_word}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // event-status style query, two replies
    run_txn(8'h0C, 0, 32'h0, 2, 8'h5A, 32'h0000_3CA5, 2, 0, 0, 0, 0, 0, 6, 0);
    // external-status style query after two stale bytes (R2)
    run_txn(8'h11, 0, 32'h0, 2, 8'h66, 32'h0000_3412, 2, 0, 0, 0, 2, 0, 8, 0);
    // arguments with a throttled transmit side and a start while busy (R1)
    run_txn(8'h41, 3, 32'h0033_2211, 1, 8'hC3, 32'h0000_00B7, 1, 0, 0, 1, 0, 1, -1, 0);
    // counts above the buffer sizes are clamped (R3, R6)
    run_txn(8'h50, 6, 32'hDD_CC_BB_AA, 7, 8'h01, 32'h44_33_22_11, 4, 0, 0, 0, 0, 0, 12, 0);
    // opcode write never gets room (R8)
    run_txn(8'h20, 0, 32'h0, 2, 8'h00, 32'h0, 0, 0, 1, 0, 0, 0, TO + 2, 1);
    // acknowledge never arrives (R8)
    run_txn(8'h0C, 0, 32'h0, 2, 8'h00, 32'h0, 0, 1, 0, 0, 0, 0, TO + 3, 1);
    // reply cut short after one byte (R8, R6)
    run_txn(8'h11, 0, 32'h0, 2, 8'h7E, 32'h0000_00F1, 1, 0, 0, 0, 0, 0, 25, 1);
    // ack only, no reply bytes; timeout flag clears (R9, R5)
    run_txn(8'h30, 1, 32'h0000_0042, 0, 8'h9C, 32'h0, 0, 0, 0, 0, 0, 0, 5, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule